// File: doc/BRIEF.md
# Rotating Command Tag Allocator

This block issues command-queue tags to a storage port from a fixed pool. A requester raises an allocate strobe. The block then picks a free tag and, one clock later, reports either that tag with a valid flag or a pulse meaning the pool is exhausted. Tags come back through a release port that carries the tag number. A freeze input stops all allocation while the port recovers from an error.

The block does not always return the lowest free tag. It keeps the most recently granted tag and starts each search at the tag just above it, wrapping around at the end of the pool. As a result, tags cycle through the whole pool instead of one small group being reused. The highest tag can be held back for internal commands, and in that case it is never handed out. The search is a rotate followed by a priority encoder, all combinational, and the result is registered.

Top module: `tag_allocator`

## Requirements
- R1: After reset `grant_valid` and `grant_none` are low, no tag is allocated and the search start is tag 0, so the first grant returns tag 0.
- R2: An allocate request sampled at a clock edge while not frozen produces exactly one of `grant_valid` or `grant_none`, high during the following cycle only.
- R3: With `RESERVE_LAST` = 1, tag `NUM_TAGS-1` is never granted.
- R4: The candidate tags are examined in the order last+1, last+2, … modulo `NUM_TAGS`, where last is the most recently granted tag. The first free, non-reserved tag is granted and becomes the new last.
- R5: A granted tag is marked allocated and is not granted again until it has been released.
- R6: While `freeze` is high, an allocate request is ignored: both outputs stay low, and neither the allocation state nor the last-granted tag changes.
- R7: When no free non-reserved tag exists, a request yields `grant_none` high for one cycle, and the allocation state and last-granted tag are left unchanged.
- R8: A release (`rel_valid` high with `rel_tag`) frees that tag at the clock edge. An allocation sampled at the same edge does not see the freed tag; the next request can.
- R9: With no allocate request, both outputs are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request one tag |
| freeze | input | 1 | Suppress allocation while high |
| rel_valid | input | 1 | Return the tag on `rel_tag` |
| rel_tag | input | $clog2(NUM_TAGS) | Tag being returned |
| grant_valid | output | 1 | A tag was granted (one cycle) |
| grant_tag | output | $clog2(NUM_TAGS) | Granted tag number |
| grant_none | output | 1 | Request found the pool exhausted (one cycle) |

## Verification
The bench builds the block with `NUM_TAGS` = 32 and `RESERVE_LAST` = 1. With a 32-entry pool the bench can exhaust every usable tag in 31 directed requests. This shows the reserved tag being skipped at the wrap point and lets the bench watch exhaustion and the same-cycle release ordering. Random traffic then runs long enough to wrap the search pointer many times against a scattered allocation map.

// File: rtl/tag_alloc_pkg.sv
package tag_alloc_pkg;

   // Registered outcome of the previous cycle's request
   typedef enum logic [1:0] {
      RES_IDLE   = 2'd0,
      RES_GRANT  = 2'd1,
      RES_EMPTY  = 2'd2,
      RES_FROZEN = 2'd3
   } tag_res_e;

endpackage

// File: rtl/tag_rotator.sv
module tag_rotator #(
   parameter int N = 32,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] vec_in,
   input  logic [W-1:0] start,
   output logic [N-1:0] vec_out
);
   localparam logic [W:0] N_EXT = (W+1)'(N);

   // vec_out[i] = vec_in[(start + i) mod N]
   always_comb begin
      for (int i = 0; i < N; i++) begin
         logic [W:0] s;
         s = {1'b0, start} + (W+1)'(i);
         if (s >= N_EXT) s = s - N_EXT;
         vec_out[i] = vec_in[s[W-1:0]];
      end
   end
endmodule

// File: rtl/tag_prio_enc.sv
module tag_prio_enc #(
   parameter int N = 32,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] req,
   output logic         hit,
   output logic [W-1:0] idx
);
   // Lowest set bit wins
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end

   assign hit = |req;
endmodule

// File: rtl/tag_release_dec.sv
module tag_release_dec #(
   parameter int N = 32,
   localparam int W = $clog2(N)
) (
   input  logic         rel_valid,
   input  logic [W-1:0] rel_tag,
   output logic [N-1:0] clr_mask
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      assign clr_mask[g] = rel_valid && (rel_tag == W'(g));
   end
endmodule

// File: rtl/tag_allocator.sv
module tag_allocator #(
   parameter int NUM_TAGS     = 32,
   parameter bit RESERVE_LAST = 1'b1,
   localparam int TAG_W = $clog2(NUM_TAGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   input  logic             freeze,
   input  logic             rel_valid,
   input  logic [TAG_W-1:0] rel_tag,
   output logic             grant_valid,
   output logic [TAG_W-1:0] grant_tag,
   output logic             grant_none
);
   import tag_alloc_pkg::*;

   localparam int         TOP_TAG  = NUM_TAGS - 1;
   localparam logic [TAG_W:0] N_EXT = (TAG_W+1)'(NUM_TAGS);
   localparam logic [TAG_W-1:0] TOP_W = TAG_W'(TOP_TAG);

   initial begin
      if (NUM_TAGS < 2)
         $fatal(1, "tag_allocator: NUM_TAGS must be at least 2");
   end

   logic [NUM_TAGS-1:0] busy_q, busy_d;
   logic [TAG_W-1:0]    last_q;
   logic [TAG_W-1:0]    tag_q;
   tag_res_e            res_q, res_d;

   logic [NUM_TAGS-1:0] rsv_mask, free_vec, rot_vec, clr_mask, set_mask;
   logic [TAG_W-1:0]    start, off, pick_tag;
   logic [TAG_W:0]      pick_sum;
   logic                hit, do_alloc;

   // Reserved-tag variant
   if (RESERVE_LAST) begin : g_rsv
      assign rsv_mask = {1'b1, {(NUM_TAGS-1){1'b0}}};
   end else begin : g_norsv
      assign rsv_mask = '0;
   end

   assign free_vec = ~busy_q & ~rsv_mask;
   assign start    = (last_q == TOP_W) ? '0 : last_q + TAG_W'(1);

   tag_rotator #(.N(NUM_TAGS)) u_rot (
      .vec_in  (free_vec),
      .start   (start),
      .vec_out (rot_vec)
   );

   tag_prio_enc #(.N(NUM_TAGS)) u_enc (
      .req (rot_vec),
      .hit (hit),
      .idx (off)
   );

   tag_release_dec #(.N(NUM_TAGS)) u_rel (
      .rel_valid (rel_valid),
      .rel_tag   (rel_tag),
      .clr_mask  (clr_mask)
   );

   always_comb begin
      pick_sum = {1'b0, start} + {1'b0, off};
      if (pick_sum >= N_EXT) pick_sum = pick_sum - N_EXT;
   end
   assign pick_tag = pick_sum[TAG_W-1:0];

   assign do_alloc = alloc_req && !freeze && hit;
   assign set_mask = do_alloc ? (NUM_TAGS'(1) << pick_tag) : '0;
   assign busy_d   = (busy_q & ~clr_mask) | set_mask;

   always_comb begin
      if (!alloc_req)   res_d = RES_IDLE;
      else if (freeze)  res_d = RES_FROZEN;
      else if (hit)     res_d = RES_GRANT;
      else              res_d = RES_EMPTY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
         last_q <= TOP_W;
         tag_q  <= '0;
         res_q  <= RES_IDLE;
      end else begin
         busy_q <= busy_d;
         res_q  <= res_d;
         if (do_alloc) begin
            last_q <= pick_tag;
            tag_q  <= pick_tag;
         end
      end
   end

   assign grant_valid = (res_q == RES_GRANT);
   assign grant_none  = (res_q == RES_EMPTY);
   assign grant_tag   = tag_q;
endmodule

// File: rtl/tag_allocator_chk.sv
module tag_allocator_chk #(
   parameter int NUM_TAGS     = 32,
   parameter bit RESERVE_LAST = 1'b1,
   localparam int TAG_W = $clog2(NUM_TAGS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_req,
   input logic             freeze,
   input logic             grant_valid,
   input logic [TAG_W-1:0] grant_tag,
   input logic             grant_none
);
   if (RESERVE_LAST) begin : g_rsv_chk
      a_r3_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
         grant_valid |-> grant_tag != TAG_W'(NUM_TAGS - 1));
   end

   a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && !freeze) |=> (grant_valid || grant_none));

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_valid && grant_none));

   a_r6_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && freeze) |=> (!grant_valid && !grant_none));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc_req |=> (!grant_valid && !grant_none));

   a_r5_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && $past(grant_valid)) |-> grant_tag != $past(grant_tag));
endmodule

bind tag_allocator tag_allocator_chk #(
   .NUM_TAGS     (NUM_TAGS),
   .RESERVE_LAST (RESERVE_LAST)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_req   (alloc_req),
   .freeze      (freeze),
   .grant_valid (grant_valid),
   .grant_tag   (grant_tag),
   .grant_none  (grant_none)
);

// File: tb/tag_allocator_tb.sv
module tag_allocator_tb;
   localparam int N = 32;
   localparam int W = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         alloc_req = 1'b0;
   logic         freeze = 1'b0;
   logic         rel_valid = 1'b0;
   logic [W-1:0] rel_tag = '0;
   logic         grant_valid;
   logic [W-1:0] grant_tag;
   logic         grant_none;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   // Bench model
   logic [N-1:0] m_busy;
   int           m_last;
   bit           e_valid, e_none;
   int           e_tag;

   always #10 clk = ~clk;

   tag_allocator #(.NUM_TAGS(N), .RESERVE_LAST(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .freeze(freeze),
      .rel_valid(rel_valid), .rel_tag(rel_tag),
      .grant_valid(grant_valid), .grant_tag(grant_tag), .grant_none(grant_none)
   );

   function automatic int find_free(logic [N-1:0] busy, int last);
      for (int i = 0; i < N; i++) begin
         int t;
         t = (last + 1 + i) % N;
         if (t != N - 1 && !busy[t]) return t;
      end
      return -1;
   endfunction

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One cycle: compute expectation, drive at negedge, compare at next negedge
   task automatic step(bit req, bit frz, bit rv, int rt, string lbl);
      int t;
      logic [N-1:0] clr;
      e_valid = 1'b0; e_none = 1'b0;
      if (req && !frz) begin
         t = find_free(m_busy, m_last);
         if (t < 0) e_none = 1'b1;
         else begin e_valid = 1'b1; e_tag = t; end
      end
      clr = rv ? (N'(1) << rt) : '0;
      m_busy = m_busy & ~clr;
      if (e_valid) begin m_busy[e_tag] = 1'b1; m_last = e_tag; end
      alloc_req = req; freeze = frz; rel_valid = rv; rel_tag = W'(rt);
      @(negedge clk);
      check(lbl, int'(grant_valid), int'(e_valid));
      check(lbl, int'(grant_none), int'(e_none));
      if (e_valid) begin
         check(lbl, int'(grant_tag), e_tag);
         n_checks++;
         if (grant_tag == W'(N - 1)) begin
            n_fails++;
            $display("FAIL R3: actual %0d expected not %0d", grant_tag, N - 1);
         end
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      m_busy = '0; m_last = N - 1;
      repeat (3) @(negedge clk);
      check("R1", int'(grant_valid), 0);
      check("R1", int'(grant_none), 0);
      rst_n = 1'b1;
      @(negedge clk);
      step(1, 0, 0, 0, "R1");            // first grant is tag 0
      step(0, 0, 0, 0, "R9");
      step(1, 1, 0, 0, "R6");            // frozen: ignored
      step(1, 0, 0, 0, "R6");            // state unchanged: tag 1 next
      for (int k = 0; k < 29; k++) step(1, 0, 0, 0, "R5");
      check("R4", m_last, 30);
      step(1, 0, 0, 0, "R7");            // pool exhausted
      step(1, 0, 1, 5, "R8");            // release unseen this cycle
      step(1, 0, 0, 0, "R8");            // now tag 5
      step(0, 0, 1, 2, "R8");
      step(0, 0, 1, 10, "R8");
      step(1, 0, 0, 0, "R4");            // from last=5: 10 before 2
      step(1, 0, 0, 0, "R4");            // wraps past 31 to 2
      step(1, 1, 1, 7, "R6");            // release while frozen
      step(1, 0, 0, 0, "R2");            // 7
      for (int k = 0; k < 3000; k++) begin
         bit r, f, rv;
         int rt;
         r  = ($urandom % 100) < 55;
         f  = ($urandom % 100) < 8;
         rv = ($urandom % 100) < 45;
         rt = int'($urandom % N);
         step(r, f, rv, rt, (r && !f) ? "R4" : (r ? "R6" : "R9"));
      end
      step(0, 0, 0, 0, "R9");
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule